// File: doc/BRIEF.md
# Rolling-Minimum Flow Counter Pipeline

This block counts packets per flow in a small, fixed set of stages. Each stage owns one table of slots. A slot holds a valid bit, a flow identifier and a count. A packet's flow identifier enters the first stage and picks one slot in each stage from a fixed bit slice of the identifier. The first stage always admits the new flow. A flow that is pushed out of a slot travels down the pipeline as a carried entry. At each later stage it either merges into its own slot, settles in an empty slot, or trades places with a smaller resident. Whatever is still being carried after the last stage is dropped. As a result, large flows tend to stay in the tables while small ones drift out. The same flow may hold slots in several stages at once.

The block takes one packet per clock with no stall. A control-side read port returns the contents of any slot one cycle after the request.

Top module: `flow_evict_pipe`

## Requirements
- R1: After reset every slot of every stage reads back as empty (valid bit 0).
- R2: Stage k uses slot index `pkt_id[k*IDX_W +: IDX_W]`, with stage 0 the entry stage; with the defaults that is bits 2:0, 5:3, 8:6 and 11:9.
- R3: In stage 0, when the selected slot is valid and holds the packet's identifier, its count grows by one and the packet goes no further.
- R4: In stage 0, an empty selected slot takes the packet's identifier with count 1 and the packet goes no further.
- R5: In stage 0, a selected slot holding another flow is overwritten with the packet's identifier at count 1. The previous identifier and count move on as the carried entry.
- R6: In a later stage, a valid slot with the carried identifier adds the carried count to its own, and carrying stops.
- R7: In a later stage, an empty selected slot receives the carried identifier and count, and carrying stops.
- R8: In a later stage, a carried count strictly larger than the resident count swaps the two. The resident becomes the carried entry for the next stage.
- R9: In a later stage, a carried count equal to or smaller than the resident count leaves the slot unchanged. The carried entry moves on to the next stage.
- R10: An entry still carried out of the last stage is dropped and appears in no slot.
- R11: A new packet may enter on every cycle. Back-to-back packets that select the same slot see each other's updates, so the result equals processing the packets one after another.
- R12: A flow may occupy slots in more than one stage at the same time.
- R13: A read request (`rd_req` high with `rd_stage`, `rd_idx`) gives `rd_ack` high on the next cycle. At the same time it returns that slot's valid bit, identifier and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A packet is presented this cycle |
| pkt_id | input | ID_W | Flow identifier of the packet |
| rd_req | input | 1 | Slot read request |
| rd_stage | input | STG_W | Stage to read |
| rd_idx | input | IDX_W | Slot index to read |
| rd_ack | output | 1 | Read data valid (one cycle after rd_req) |
| rd_slot_vld | output | 1 | Valid bit of the slot read |
| rd_slot_id | output | ID_W | Flow identifier of the slot read |
| rd_slot_cnt | output | CNT_W | Count of the slot read |

## Verification
A packet presented in cycle t updates stage k at the clock edge that ends cycle t+k. Its effect on the last stage is therefore settled STAGES cycles after it enters. A read answers on the edge after its request, with the slot contents as they stood during the request cycle. The bench therefore holds the input idle for STAGES+2 cycles after each burst before reading anything. Its scoreboard pushes the expected slot when a request is driven and pops it at the falling edge that follows the `rd_ack` edge. Expected contents come from a sequential flow-table model updated as each packet is driven. Bursts are issued back-to-back so that same-slot collisions between neighbouring packets are exercised.

// File: rtl/fep_pkg.sv
`timescale 1ns/1ps
package fep_pkg;
  // Decision taken by a stage for the entry that reaches it
  typedef enum logic [2:0] {
    ACT_IDLE  = 3'd0,
    ACT_MATCH = 3'd1,
    ACT_FILL  = 3'd2,
    ACT_SWAP  = 3'd3,
    ACT_PASS  = 3'd4
  } fep_act_e;
endpackage

// File: rtl/fep_stage.sv
`timescale 1ns/1ps
module fep_stage
  import fep_pkg::*;
#(
  parameter int ID_W  = 16,
  parameter int CNT_W = 16,
  parameter int IDX_W = 3,
  parameter int STAGE = 0,
  parameter bit FIRST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [ID_W-1:0]  in_id,
  input  logic [CNT_W-1:0] in_cnt,
  output logic             out_vld,
  output logic [ID_W-1:0]  out_id,
  output logic [CNT_W-1:0] out_cnt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [ID_W-1:0]  rd_id,
  output logic [CNT_W-1:0] rd_cnt
);
  localparam int SLOTS = 1 << IDX_W;
  localparam int LSB   = STAGE * IDX_W;

  logic [SLOTS-1:0] slot_vld;
  logic [ID_W-1:0]  slot_id  [SLOTS];
  logic [CNT_W-1:0] slot_cnt [SLOTS];

  logic [IDX_W-1:0] idx;
  logic             cur_vld;
  logic [ID_W-1:0]  cur_id;
  logic [CNT_W-1:0] cur_cnt;
  logic             hit;
  logic             beats;
  fep_act_e         act;

  logic             wr_en;
  logic [ID_W-1:0]  wr_id;
  logic [CNT_W-1:0] wr_cnt;

  assign idx     = in_id[LSB +: IDX_W];
  assign cur_vld = slot_vld[idx];
  assign cur_id  = slot_id[idx];
  assign cur_cnt = slot_cnt[idx];
  assign hit     = cur_vld && (cur_id == in_id);

  // Entry stage always admits; later stages admit only a strictly larger count
  generate
    if (FIRST) begin : g_admit_always
      assign beats = 1'b1;
    end else begin : g_admit_larger
      assign beats = (in_cnt > cur_cnt);
    end
  endgenerate

  always_comb begin
    act = ACT_IDLE;
    if (in_vld) begin
      if (hit)           act = ACT_MATCH;
      else if (!cur_vld) act = ACT_FILL;
      else if (beats)    act = ACT_SWAP;
      else               act = ACT_PASS;
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_id   = in_id;
    wr_cnt  = in_cnt;
    out_vld = 1'b0;
    out_id  = in_id;
    out_cnt = in_cnt;
    case (act)
      ACT_MATCH: begin
        wr_en  = 1'b1;
        wr_cnt = cur_cnt + in_cnt;
      end
      ACT_FILL: begin
        wr_en = 1'b1;
      end
      ACT_SWAP: begin
        wr_en   = 1'b1;
        out_vld = 1'b1;
        out_id  = cur_id;
        out_cnt = cur_cnt;
      end
      ACT_PASS: begin
        out_vld = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld <= '0;
    end else if (wr_en) begin
      slot_vld[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot_id[idx]  <= wr_id;
      slot_cnt[idx] <= wr_cnt;
    end
  end

  assign rd_vld = slot_vld[rd_idx];
  assign rd_id  = slot_id[rd_idx];
  assign rd_cnt = slot_cnt[rd_idx];

  // R11
  raw_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && $past(rst_n) && $past(wr_en) && (idx == $past(idx)))
      |-> (cur_vld && (cur_id == $past(wr_id)) && (cur_cnt == $past(wr_cnt))));

  generate
    if (FIRST) begin : g_head_chk
      // R5
      head_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> (wr_en && (wr_id == in_id)));
    end else begin : g_tail_chk
      // R8
      swap_smaller_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && wr_en) |-> (out_cnt < wr_cnt));
      // R9
      pass_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !wr_en) |-> (cur_vld && (out_cnt <= cur_cnt) && (out_id != cur_id)));
    end
  endgenerate

endmodule

// File: rtl/flow_evict_pipe.sv
`timescale 1ns/1ps
module flow_evict_pipe #(
  parameter int ID_W   = 16,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 3,
  parameter int STAGES = 4,
  localparam int STG_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [ID_W-1:0]  pkt_id,
  input  logic             rd_req,
  input  logic [STG_W-1:0] rd_stage,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_ack,
  output logic             rd_slot_vld,
  output logic [ID_W-1:0]  rd_slot_id,
  output logic [CNT_W-1:0] rd_slot_cnt
);
  localparam int LAST = STAGES - 1;

  // Stage outputs (carried entries) and inter-stage registers
  logic [STAGES-1:0] so_vld;
  logic [ID_W-1:0]   so_id  [STAGES];
  logic [CNT_W-1:0]  so_cnt [STAGES];

  logic [STAGES-2:0] pr_vld;
  logic [ID_W-1:0]   pr_id  [STAGES-1];
  logic [CNT_W-1:0]  pr_cnt [STAGES-1];

  // Per-stage read data
  logic [STAGES-1:0] sr_vld;
  logic [ID_W-1:0]   sr_id  [STAGES];
  logic [CNT_W-1:0]  sr_cnt [STAGES];

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_head
        fep_stage #(
          .ID_W(ID_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .STAGE(0), .FIRST(1'b1)
        ) u_stage (
          .clk(clk), .rst_n(rst_n),
          .in_vld(pkt_valid), .in_id(pkt_id), .in_cnt(CNT_W'(1)),
          .out_vld(so_vld[k]), .out_id(so_id[k]), .out_cnt(so_cnt[k]),
          .rd_idx(rd_idx),
          .rd_vld(sr_vld[k]), .rd_id(sr_id[k]), .rd_cnt(sr_cnt[k])
        );
      end else begin : g_tail
        fep_stage #(
          .ID_W(ID_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .STAGE(k), .FIRST(1'b0)
        ) u_stage (
          .clk(clk), .rst_n(rst_n),
          .in_vld(pr_vld[k-1]), .in_id(pr_id[k-1]), .in_cnt(pr_cnt[k-1]),
          .out_vld(so_vld[k]), .out_id(so_id[k]), .out_cnt(so_cnt[k]),
          .rd_idx(rd_idx),
          .rd_vld(sr_vld[k]), .rd_id(sr_id[k]), .rd_cnt(sr_cnt[k])
        );
      end
    end
  endgenerate

  // Carried entries advance one stage per cycle; the last stage's carry is dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_vld <= '0;
    end else begin
      pr_vld <= so_vld[STAGES-2:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < STAGES - 1; s++) begin
      if (so_vld[s]) begin
        pr_id[s]  <= so_id[s];
        pr_cnt[s] <= so_cnt[s];
      end
    end
  end

  // Registered read port
  logic             rd_sel_vld;
  logic [ID_W-1:0]  rd_sel_id;
  logic [CNT_W-1:0] rd_sel_cnt;

  always_comb begin
    rd_sel_vld = 1'b0;
    rd_sel_id  = '0;
    rd_sel_cnt = '0;
    if (int'(rd_stage) < STAGES) begin
      rd_sel_vld = sr_vld[rd_stage];
      rd_sel_id  = sr_id[rd_stage];
      rd_sel_cnt = sr_cnt[rd_stage];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ack <= 1'b0;
    end else begin
      rd_ack <= rd_req;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_req) begin
      rd_slot_vld <= rd_sel_vld;
      rd_slot_id  <= rd_sel_id;
      rd_slot_cnt <= rd_sel_cnt;
    end
  end

  // R13
  rd_ack_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_ack);

  // R11
  carry_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_vld[0] |=> (pr_vld[0] && (pr_id[0] == $past(so_id[0])) && (pr_cnt[0] == $past(so_cnt[0]))));

  // R10
  drop_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_vld[LAST] |-> ((so_cnt[LAST] != '0) && !$isunknown(so_id[LAST])));

endmodule

// File: tb/flow_evict_pipe_tb_top.sv
`timescale 1ns/1ps
module flow_evict_pipe_tb_top;
  localparam int ID_W   = 16;
  localparam int CNT_W  = 16;
  localparam int IDX_W  = 3;
  localparam int STAGES = 4;
  localparam int SLOTS  = 1 << IDX_W;
  localparam int STG_W  = 2;

  logic             clk;
  logic             rst_n;
  logic             pkt_valid;
  logic [ID_W-1:0]  pkt_id;
  logic             rd_req;
  logic [STG_W-1:0] rd_stage;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_ack;
  logic             rd_slot_vld;
  logic [ID_W-1:0]  rd_slot_id;
  logic [CNT_W-1:0] rd_slot_cnt;

  flow_evict_pipe #(.ID_W(ID_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .STAGES(STAGES)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .pkt_valid(pkt_valid), .pkt_id(pkt_id),
    .rd_req(rd_req), .rd_stage(rd_stage), .rd_idx(rd_idx),
    .rd_ack(rd_ack), .rd_slot_vld(rd_slot_vld),
    .rd_slot_id(rd_slot_id), .rd_slot_cnt(rd_slot_cnt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  // Sequential reference of the flow tables
  bit              m_vld [STAGES][SLOTS];
  logic [ID_W-1:0] m_id  [STAGES][SLOTS];
  int              m_cnt [STAGES][SLOTS];

  typedef struct {
    int              stg;
    int              idx;
    bit              vld;
    logic [ID_W-1:0] id;
    int              cnt;
    string           tag;
  } exp_t;
  exp_t sb_q[$];

  function automatic int slot_of(logic [ID_W-1:0] id, int s);
    return int'((id >> (s * IDX_W)) & ID_W'(SLOTS - 1));
  endfunction

  function automatic logic [ID_W-1:0] mk(int hi, int f3, int f2, int f1, int f0);
    return {hi[3:0], f3[2:0], f2[2:0], f1[2:0], f0[2:0]};
  endfunction

  task automatic model_pkt(input logic [ID_W-1:0] id);
    bit              cv = 1'b1;
    logic [ID_W-1:0] cid = id;
    int              cc = 1;
    for (int s = 0; s < STAGES; s++) begin
      int ix;
      if (!cv) break;
      ix = slot_of(cid, s);
      if (m_vld[s][ix] && m_id[s][ix] == cid) begin
        m_cnt[s][ix] += cc;
        cv = 1'b0;
      end else if (!m_vld[s][ix]) begin
        m_vld[s][ix] = 1'b1; m_id[s][ix] = cid; m_cnt[s][ix] = cc;
        cv = 1'b0;
      end else if (s == 0 || cc > m_cnt[s][ix]) begin
        logic [ID_W-1:0] tid = m_id[s][ix];
        int              tc  = m_cnt[s][ix];
        m_id[s][ix] = cid; m_cnt[s][ix] = cc;
        cid = tid; cc = tc;
      end
    end
  endtask

  task automatic send(input logic [ID_W-1:0] id);
    @(negedge clk);
    pkt_valid = 1'b1;
    pkt_id    = id;
    model_pkt(id);
  endtask

  task automatic drain();
    @(negedge clk);
    pkt_valid = 1'b0;
    repeat (STAGES + 2) @(negedge clk);
  endtask

  task automatic rd_slot(input int s, input int i, input string tag);
    exp_t e;
    @(negedge clk);
    rd_req   = 1'b1;
    rd_stage = STG_W'(s);
    rd_idx   = IDX_W'(i);
    e.stg = s; e.idx = i; e.vld = m_vld[s][i];
    e.id  = m_id[s][i]; e.cnt = m_cnt[s][i]; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic dump(input string tag);
    for (int s = 0; s < STAGES; s++)
      for (int i = 0; i < SLOTS; i++)
        rd_slot(s, i, tag);
    @(negedge clk);
    rd_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: compares each read response with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && rd_ack) begin
      exp_t e;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R13 unexpected rd_ack: got ack=1 expected no ack");
      end else begin
        bit bad;
        e = sb_q.pop_front();
        bad = (rd_slot_vld !== e.vld);
        if (e.vld && !bad)
          bad = (rd_slot_id !== e.id) || (int'(rd_slot_cnt) != e.cnt);
        if (bad) begin
          errors++;
          $display("FAIL %s stage%0d slot%0d: got vld=%0b id=%h cnt=%0d expected vld=%0b id=%h cnt=%0d",
                   e.tag, e.stg, e.idx, rd_slot_vld, rd_slot_id, rd_slot_cnt,
                   e.vld, e.id, e.cnt);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got run still active expected completion");
    finish_run();
  end

  logic [ID_W-1:0] fa, fb, fe, ff, fg, fh, fj, fk, fl;
  logic [15:0]     lfsr;

  initial begin
    for (int s = 0; s < STAGES; s++)
      for (int i = 0; i < SLOTS; i++) begin
        m_vld[s][i] = 1'b0; m_id[s][i] = '0; m_cnt[s][i] = 0;
      end
    rst_n = 1'b0; pkt_valid = 1'b0; pkt_id = '0;
    rd_req = 1'b0; rd_stage = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    dump("R1 R13");

    // R4 then R3 on the same slot, back to back (R11); slot choice per R2
    fa = mk(1, 1, 1, 1, 0);
    send(fa); send(fa); send(fa);
    drain();
    dump("R4 R3 R11 R2");

    // R5: overwrite at entry, carried A settles in an empty stage-1 slot (R7)
    fb = mk(2, 2, 2, 2, 0);
    send(fb);
    drain();
    dump("R5 R7");

    // R8: E grows to 5, then F pushes E down onto A(3) at stage 1
    fe = mk(3, 5, 5, 1, 0);
    for (int n = 0; n < 5; n++) send(fe);
    ff = mk(4, 6, 6, 6, 0);
    send(ff);
    drain();
    dump("R8");

    // R9: smaller and equal carried counts pass over residents
    fg = mk(5, 7, 7, 1, 0);
    fh = mk(6, 0, 0, 1, 0);
    fj = mk(7, 3, 3, 2, 0);
    fk = mk(8, 4, 4, 4, 0);
    send(fg); send(fh); send(fj); send(fk);
    drain();
    dump("R9");

    // R12: A re-enters at stage 0 while still resident deeper
    send(fa);
    drain();
    dump("R12");

    // R6: A's entry-stage copy is pushed down and merges with its deeper copy
    fl = mk(9, 1, 1, 1, 0);
    send(fl);
    drain();
    dump("R6");

    // R10: many flows colliding at every stage force drops after the last stage
    for (int h = 10; h < 16; h++) send(mk(h, 0, 0, 0, 0));
    for (int h = 10; h < 16; h++) send(mk(h, 0, 0, 0, 0));
    drain();
    dump("R10");

    // R11 R2: dense back-to-back stream over a small flow set
    lfsr = 16'hACE1;
    for (int n = 0; n < 60; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(16'hC000 | {12'd0, lfsr[3:0]});
    end
    drain();
    dump("R11 R2");

    if (sb_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R13 missing responses: got %0d pending expected 0", sb_q.size());
    end
    finish_run();
  end

endmodule